// File: doc/BRIEF.md
# Cascaded Search Result Arbiter

Several search engines are stacked to act as one large associative database. Every engine is handed the same search key in the same cycle. Each engine then reports whether it found a match and, if so, the local index of that match. This block takes those per-engine results and picks one global winner. The winner is the matching entry that lies nearest to address 0 of the combined database. The block raises the winner's success flag and forms the external SRAM address that fetches the data associated with that entry.

Engine k owns combined addresses k*N up to k*N+N-1, where N is the number of entries in one engine. Because of this, the lowest-numbered engine that hits always wins.

The result does not leave the block in the cycle it is decided. It goes through a fixed pipeline, so that the winner flags, the valid qualifier and the SRAM chip and output enables reach the host together. Every search yields exactly one valid cycle, whether or not any engine hit. A search only reads, so the shared SRAM write enable is not driven by this block. Output enable models the pin driven by the last device in the cascade, and it follows the same timing as chip enable.

Top module: `casc_search_arbiter`

## Requirements
- R1: If `search_go` is sampled high at rising edge n, `res_valid` is high for exactly the one cycle that follows edge n+LAT-1 (LAT defaults to 4), and it is never high for any other reason.
- R2: In a valid result, `win_flag` has exactly one bit set when any engine hit. That bit belongs to the lowest-numbered engine whose `eng_hit` bit was high at issue.
- R3: In a valid result with a hit, `sram_addr` equals the winner's engine number in the upper bits, concatenated with that engine's local index taken from `eng_idx` (engine k uses bits k*IDX_W upward), zero-extended to SADR_W bits.
- R4: In a valid result with no hit, `win_flag` is all zero, `sram_addr` is zero and `sram_ce_n` stays high.
- R5: `sram_ce_n` and `sram_oe_n` are low exactly in valid cycles that carry a hit, and they are equal in every cycle.
- R6: Searches issued in consecutive cycles each give their own result, in issue order, in consecutive cycles.
- R7: `eng_hit` and `eng_idx` are ignored in cycles where `search_go` is low. No result and no winner flag comes from them.
- R8: While `rst_n` is low and right after it, `res_valid` and `win_flag` are zero, `sram_addr` is zero, and both enables are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| search_go | input | 1 | A search is issued this cycle |
| eng_hit | input | NUM_ENG | Per-engine match flag, bit k for engine k |
| eng_idx | input | NUM_ENG*IDX_W | Per-engine local index, packed, engine 0 in the low bits |
| win_flag | output | NUM_ENG | Per-engine global winner flag |
| res_valid | output | 1 | Qualifies the winner flags for one cycle |
| sram_addr | output | SADR_W | Address of the winner's associated data |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |
| sram_oe_n | output | 1 | Active-low SRAM output enable, as driven by the last device |

## Verification
The assertions assume that the hit and index inputs are known whenever `search_go` is high. The bench therefore drives every input to a defined value, changes it only on falling edges, and sets inputs to zero between searches apart from the deliberate noise used for R7. They also assume reset lasts at least one edge. The bench holds it for several cycles before the first search. The stimulus includes single hits at each end of the cascade, ties between several engines, all-hit and no-hit patterns, and back-to-back issue. Each expected result is computed from the priority rule alone.

// File: rtl/casc_arb_pkg.sv
// Shared defaults for the cascaded search result arbiter.
// Assumes: all sizing is overridden at the top level when needed.
package casc_arb_pkg;
    localparam int DEF_ENGINES = 4;
    localparam int DEF_IDX_W   = 12;
    localparam int DEF_SADR_W  = 22;
    localparam int DEF_LAT     = 4;

    // Bits needed to number n engines, at least one.
    function automatic int eng_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/prio_pick.sv
// Fixed-priority winner selection across engines.
// Does: finds the lowest-numbered engine with a hit and returns its one-hot
// flag, its number and its local index.
// Assumes: inputs are stable during the issue cycle; purely combinational.
module prio_pick #(
    parameter int NUM_ENG = 4,
    parameter int IDX_W   = 12,
    parameter int ENG_W   = 2
) (
    input  logic [NUM_ENG-1:0]       hit,
    input  logic [NUM_ENG*IDX_W-1:0] idx_flat,
    output logic                     any_hit,
    output logic [NUM_ENG-1:0]       win_oh,
    output logic [ENG_W-1:0]         win_num,
    output logic [IDX_W-1:0]         win_idx
);
    // Walk from the highest engine down so the lowest hitting one is kept last.
    always_comb begin
        any_hit = 1'b0;
        win_oh  = '0;
        win_num = '0;
        win_idx = '0;
        for (int k = NUM_ENG - 1; k >= 0; k--) begin
            if (hit[k]) begin
                any_hit = 1'b1;
                win_oh  = '0;
                win_oh[k] = 1'b1;
                win_num = ENG_W'(k);
                win_idx = idx_flat[k*IDX_W +: IDX_W];
            end
        end
    end
endmodule

// File: rtl/res_pipe.sv
// Fixed-latency alignment pipeline for search results.
// Does: delays a valid bit and its payload by LAT register stages.
// Assumes: LAT >= 1; payload is zero whenever the valid bit is low.
module res_pipe #(
    parameter int W   = 8,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    logic         stg_v [LAT];
    logic [W-1:0] stg_d [LAT];

    for (genvar i = 0; i < LAT; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the freshly arbitrated result.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[0] <= 1'b0;
                    stg_d[0] <= '0;
                end else begin
                    stg_v[0] <= in_v;
                    stg_d[0] <= in_d;
                end
            end
        end else begin : g_next
            // Advance the result by one stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[i] <= 1'b0;
                    stg_d[i] <= '0;
                end else begin
                    stg_v[i] <= stg_v[i-1];
                    stg_d[i] <= stg_d[i-1];
                end
            end

            AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
                stg_v[i-1] |=> stg_v[i]); // R1
        end
    end

    assign out_v = stg_v[LAT-1];
    assign out_d = stg_d[LAT-1];
endmodule

// File: rtl/casc_search_arbiter.sv
// Cascaded search result arbiter (top).
// Does: picks the global winner among per-engine hits by combined address,
// forms the SRAM address, and releases flags and SRAM enables after a fixed
// pipeline latency.
// Assumes: every engine reports in the cycle search_go is high; engine k
// spans combined addresses k*2^IDX_W upward.
module casc_search_arbiter
    import casc_arb_pkg::*;
#(
    parameter int NUM_ENG = DEF_ENGINES,
    parameter int IDX_W   = DEF_IDX_W,
    parameter int SADR_W  = DEF_SADR_W,
    parameter int LAT     = DEF_LAT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     search_go,
    input  logic [NUM_ENG-1:0]       eng_hit,
    input  logic [NUM_ENG*IDX_W-1:0] eng_idx,
    output logic [NUM_ENG-1:0]       win_flag,
    output logic                     res_valid,
    output logic [SADR_W-1:0]        sram_addr,
    output logic                     sram_ce_n,
    output logic                     sram_oe_n
);
    localparam int ENG_W = eng_bits(NUM_ENG);
    localparam int CAT_W = ENG_W + IDX_W;
    localparam int PAY_W = 1 + NUM_ENG + SADR_W;

    logic               any_hit;
    logic [NUM_ENG-1:0] pick_oh;
    logic [ENG_W-1:0]   pick_num;
    logic [IDX_W-1:0]   pick_idx;
    logic [SADR_W-1:0]  pick_addr;
    logic [PAY_W-1:0]   pay_in, pay_out;
    logic               pipe_v;
    logic               out_hit;

    prio_pick #(.NUM_ENG(NUM_ENG), .IDX_W(IDX_W), .ENG_W(ENG_W)) u_pick (
        .hit      (eng_hit),
        .idx_flat (eng_idx),
        .any_hit  (any_hit),
        .win_oh   (pick_oh),
        .win_num  (pick_num),
        .win_idx  (pick_idx)
    );

    // Combined-database address of the winner, zero-extended.
    assign pick_addr = SADR_W'({pick_num, pick_idx});

    // Only a real search with a hit loads a non-zero payload.
    always_comb begin
        pay_in = '0;
        if (search_go && any_hit)
            pay_in = {1'b1, pick_oh, pick_addr};
    end

    res_pipe #(.W(PAY_W), .LAT(LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (search_go),
        .in_d  (pay_in),
        .out_v (pipe_v),
        .out_d (pay_out)
    );

    // Unpack the aligned result onto the host-facing outputs.
    always_comb begin
        out_hit   = pay_out[PAY_W-1];
        win_flag  = pay_out[SADR_W +: NUM_ENG];
        sram_addr = pay_out[SADR_W-1:0];
        res_valid = pipe_v;
        sram_ce_n = ~(pipe_v & out_hit);
        sram_oe_n = ~(pipe_v & out_hit);
    end

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_flag)); // R2
    AST_PICK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        search_go |-> ((pick_oh & ~eng_hit) == '0)); // R2
    AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (win_flag != '0) |-> res_valid); // R1
    AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid || sram_ce_n) |-> (sram_addr == '0)); // R4
    AST_OE_TRACKS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_oe_n == sram_ce_n); // R5
    AST_CE_ONLY_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> (win_flag != '0)); // R5
    localparam int unused_cat = CAT_W;
endmodule

// File: tb/sim_casc_search_arbiter.sv
// Directed bench for casc_search_arbiter: one task per scenario.
module sim_casc_search_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NE   = 4;
    localparam int IW   = 12;
    localparam int SW   = 22;
    localparam int LAT  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             search_go = 1'b0;
    logic [NE-1:0]    eng_hit = '0;
    logic [NE*IW-1:0] eng_idx = '0;
    logic [NE-1:0]    win_flag;
    logic             res_valid;
    logic [SW-1:0]    sram_addr;
    logic             sram_ce_n;
    logic             sram_oe_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected outputs, index 0 pushed at the previous falling edge.
    logic          h_v   [LAT];
    logic [NE-1:0] h_f   [LAT];
    logic [SW-1:0] h_a   [LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_search_arbiter #(.NUM_ENG(NE), .IDX_W(IW), .SADR_W(SW), .LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .search_go(search_go), .eng_hit(eng_hit),
        .eng_idx(eng_idx), .win_flag(win_flag), .res_valid(res_valid),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n)
    );

    task automatic check(input string tag, input logic v, input logic [NE-1:0] f,
                         input logic [SW-1:0] a);
        logic ce;
        ce = ~(v & (f != '0));
        checks++;
        if (res_valid !== v || win_flag !== f || sram_addr !== a ||
            sram_ce_n !== ce || sram_oe_n !== ce) begin
            failures++;
            $display("FAIL %s: got v=%b f=%b a=%h ce=%b oe=%b exp v=%b f=%b a=%h ce=%b",
                     tag, res_valid, win_flag, sram_addr, sram_ce_n, sram_oe_n, v, f, a, ce);
        end
    endtask

    // One falling edge: compare the oldest expectation, then drive new inputs.
    task automatic step(input string tag, input logic go, input logic [NE-1:0] hit,
                        input logic [NE*IW-1:0] idx);
        logic [NE-1:0] ef;
        logic [SW-1:0] ea;
        @(negedge clk);
        check(tag, h_v[LAT-1], h_f[LAT-1], h_a[LAT-1]);
        ef = '0;
        ea = '0;
        if (go) begin
            for (int k = 0; k < NE; k++) begin
                if (hit[k] && ef == '0) begin
                    ef[k] = 1'b1;
                    ea = SW'(k * (2**IW) + int'(idx[k*IW +: IW]));
                end
            end
        end
        for (int i = LAT - 1; i > 0; i--) begin
            h_v[i] = h_v[i-1];
            h_f[i] = h_f[i-1];
            h_a[i] = h_a[i-1];
        end
        h_v[0] = go;
        h_f[0] = ef;
        h_a[0] = ea;
        search_go = go;
        eng_hit = hit;
        eng_idx = idx;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < LAT + 1; i++) step(tag, 1'b0, '0, '0);
    endtask

    function automatic logic [NE*IW-1:0] idxs(input int a, input int b, input int c,
                                               input int d);
        return {IW'(d), IW'(c), IW'(b), IW'(a)};
    endfunction

    task automatic t_reset;
        for (int i = 0; i < LAT; i++) begin
            h_v[i] = 1'b0; h_f[i] = '0; h_a[i] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 in reset", 1'b0, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", 1'b0, '0, '0);
    endtask

    task automatic t_single_hits;
        step("R1 R3 engine0", 1'b1, 4'b0001, idxs(12'h0a5, 0, 0, 0));
        drain("R1 single");
        step("R3 last engine top index", 1'b1, 4'b1000, idxs(0, 0, 0, 12'hfff));
        drain("R1 single");
        step("R3 engine2", 1'b1, 4'b0100, idxs(0, 0, 12'h123, 0));
        drain("R1 single");
    endtask

    task automatic t_ties;
        step("R2 tie 1 and 3", 1'b1, 4'b1010, idxs(0, 12'h011, 0, 12'h022));
        drain("R2 tie");
        step("R2 all hit", 1'b1, 4'b1111, idxs(12'h7, 12'h8, 12'h9, 12'ha));
        drain("R2 all");
        step("R2 tie 2 and 3", 1'b1, 4'b1100, idxs(12'h1, 12'h2, 12'h333, 12'h444));
        drain("R2 tie");
    endtask

    task automatic t_no_hit;
        step("R4 no hit", 1'b1, 4'b0000, idxs(12'hfff, 12'hfff, 12'hfff, 12'hfff));
        drain("R4 R5 no hit");
    endtask

    task automatic t_back_to_back;
        step("R6 first", 1'b1, 4'b0010, idxs(0, 12'h055, 0, 0));
        step("R6 second", 1'b1, 4'b0000, idxs(0, 0, 0, 0));
        step("R6 third", 1'b1, 4'b1000, idxs(0, 0, 0, 12'h0aa));
        step("R6 fourth", 1'b1, 4'b0101, idxs(12'h3c3, 0, 12'h111, 0));
        step("R6 fifth", 1'b1, 4'b0100, idxs(0, 0, 12'h0f0, 0));
        drain("R6 R1 stream");
    endtask

    task automatic t_ignored;
        step("R7 noise", 1'b0, 4'b1111, idxs(12'h1, 12'h2, 12'h3, 12'h4));
        step("R7 noise", 1'b0, 4'b0110, idxs(12'h5, 12'h6, 12'h7, 12'h8));
        step("R7 noise", 1'b0, 4'b1001, idxs(12'h9, 12'ha, 12'hb, 12'hc));
        drain("R7 ignored");
    endtask

    initial begin
        t_reset();
        t_single_hits();
        t_ties();
        t_no_hit();
        t_back_to_back();
        t_ignored();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule